// File: doc/BRIEF.md
# Three-Channel Programmable Clock Output Divider

This block drives three clock output pins from two reference rates that reach it as single-cycle enable strobes in the system clock domain. One strobe train is a slow 32768 Hz reference. The other is a fast reference of about 4 MHz. Each output channel has one 8-bit control register on a simple synchronous register port. The register turns the channel on or off, picks which strobe train it counts, and sets a two-stage division ratio. The result is a square wave on that channel's pin.

The fast path divides first by a pre-divisor and then by a power of two. The slow path skips the pre-divisor entirely, so only the power-of-two stage applies there. Any write to a channel's register restarts that channel cleanly from a low output. This means software can retune a pin without producing a runt period.

Top module: `ckout_top`

## Requirements
- R1: Channel i's control register sits at address BASE_ADDR+i, for i = 0 to 2. A write stores the data, and `reg_rdata` returns the stored value in the same cycle the address is presented. A synchronous active-low reset clears all three registers to zero.
- R2: A write to any address outside the three channel addresses leaves every register unchanged, and reading such an address returns zero.
- R3: Bit 0 of a register enables the channel. While it is 0, the channel's pin stays low whatever strobes arrive. After the bit is set again, the first period starts from the following strobes.
- R4: Bit 4 selects the strobe train: 0 selects the slow reference and 1 selects the fast reference. Strobes on the unselected train never change the pin.
- R5: Bits 3:1 hold an exponent n from 0 to 7, which multiplies the division ratio by 2^n.
- R6: When the fast train is selected, bits 7:5 hold a pre-divisor code. Codes 0 to 6 divide by 2^code, and code 7 divides by 122.
- R7: When the slow train is selected, bits 7:5 have no effect on the output.
- R8: Let D be the pre-divisor times 2^n, with D of 2 or more. The pin then toggles on every D/2-th selected strobe, giving a 50 % duty square wave. After a register write, the first rise comes on the D/2-th strobe. The pin changes on the clock edge that samples that strobe.
- R9: When D equals 1, the pin is high for exactly the one cycle after each selected strobe, and low otherwise.
- R10: A write to a channel's register clears that channel's count and drives its pin low on the write edge. A strobe arriving in the same cycle as the write is not counted.
- R11: Each channel divides independently. A write to one channel does not disturb the count or the pin of another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_stb | input | 1 | One-cycle strobe at the 32768 Hz reference rate |
| fast_stb | input | 1 | One-cycle strobe at the fast reference rate |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, zero when out of range |
| ck_out | output | NUM_CH | Divided clock outputs, one bit per channel |

## Verification
The divide path is tried with several settings:
- The unit ratio on the slow train separates the pulse mode from the toggle mode.
- A slow setting with the pre-divisor code at its maximum shows that the code is ignored on that path.
- Fast settings with code 7, with code 3 and n = 2, and with code 0 and n = 7 separate the 122 entry, a mixed power-of-two product and the full post-divider range. The edge is checked one strobe before and exactly on each expected toggle.

Strobes on the unselected train, a write that arrives together with a strobe, a disable in mid-period and two channels with different ratios running side by side each show that only the intended events move a counter.

// File: rtl/ckout_pkg.sv
// Package: shared field layout for the clock-output control register.
// Assumes the 8-bit register layout below is fixed by software.
package ckout_pkg;

    localparam int CFG_W = 8;

    // Control register fields, most significant first (bits 7:5, 4, 3:1, 0).
    typedef struct packed {
        logic [2:0] pre_code;   // pre-divisor code, fast path only
        logic       fast_sel;   // 1: fast strobe train, 0: slow train
        logic [2:0] post_exp;   // post-divider exponent n
        logic       en;         // channel output enable
    } ckout_cfg_t;

endpackage

// File: rtl/ckout_regs.sv
// Module: ckout_regs
// Holds one control register per channel at consecutive addresses from
// BASE_ADDR. It emits a one-cycle write pulse to the written channel.
// Reads are combinational, and out-of-range accesses return zero.
// Assumes: a single write port, with no byte enables.
module ckout_regs #(
    parameter int unsigned          NUM_CH    = 3,
    parameter int unsigned          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = 8'h10
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic [ckout_pkg::CFG_W-1:0]            wdata,
    output logic [ckout_pkg::CFG_W-1:0]            rdata,
    output logic [NUM_CH-1:0][ckout_pkg::CFG_W-1:0] cfg_q,
    output logic [NUM_CH-1:0]                      ch_wr
);
    import ckout_pkg::*;

    logic [NUM_CH-1:0] hit;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
        // Address decode for channel i.
        assign hit[i]   = (addr == (BASE_ADDR + ADDR_W'(i)));
        assign ch_wr[i] = wr_en & hit[i];

        // Storage for channel i's control register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[i] <= '0;
            else if (ch_wr[i])
                cfg_q[i] <= wdata;
        end

        assert_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ch_wr[i] |=> (cfg_q[i] == $past(wdata)));
    end

    // Read mux: returns the addressed register, or zero when no slot matches.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_CH; k++)
            if (hit[k]) rdata = cfg_q[k];
    end

    assert_outside_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (hit == '0)) |=> $stable(cfg_q));

endmodule

// File: rtl/ckout_ratio.sv
// Module: ckout_ratio
// Turns the divider fields into a half-period count limit (the half period
// minus one) and a flag for unit division. The pre-divisor is applied only
// on the fast path.
// Assumes: PRE_TOP is even and at least 64, so every ratio above 1 is even.
module ckout_ratio #(
    parameter int unsigned PRE_TOP = 122,
    parameter int unsigned PRE_W   = $clog2(PRE_TOP + 1),
    parameter int unsigned FULL_W  = PRE_W + 7,
    parameter int unsigned HALF_W  = FULL_W - 1
) (
    input  logic [2:0]        pre_code,
    input  logic              fast_sel,
    input  logic [2:0]        post_exp,
    output logic [HALF_W-1:0] half_m1,
    output logic              unit_mode
);
    logic [PRE_W-1:0]  pre_val;
    logic [FULL_W-1:0] full;

    // Pre-divisor: power of two per code, top code maps to PRE_TOP, 1 on slow path.
    always_comb begin
        if (!fast_sel)
            pre_val = PRE_W'(1);
        else if (pre_code == 3'd7)
            pre_val = PRE_W'(PRE_TOP);
        else
            pre_val = PRE_W'(1) << pre_code;
    end

    // Total ratio and the half-period limit derived from it.
    always_comb begin
        full      = FULL_W'(pre_val) << post_exp;
        unit_mode = (full == FULL_W'(1));
        half_m1   = full[FULL_W-1:1] - HALF_W'(1);
    end

endmodule

// File: rtl/ckout_channel.sv
// Module: ckout_channel
// One output channel. It counts strobes on the selected train and toggles
// the pin every half period. It pulses for one cycle per strobe when the
// ratio is 1. A write pulse or a clear enable resets the count and drives
// the pin low.
// Assumes: strobes are single-cycle and synchronous to clk.
module ckout_channel #(
    parameter int unsigned PRE_TOP = 122
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  ckout_pkg::ckout_cfg_t   cfg,
    input  logic                    cfg_wr,
    input  logic                    slow_stb,
    input  logic                    fast_stb,
    output logic                    ck_out
);
    import ckout_pkg::*;

    localparam int unsigned PRE_W  = $clog2(PRE_TOP + 1);
    localparam int unsigned FULL_W = PRE_W + 7;
    localparam int unsigned HALF_W = FULL_W - 1;

    logic [HALF_W-1:0] half_m1;
    logic              unit_mode;
    logic              src_stb;
    logic [HALF_W-1:0] cnt;
    logic              out_q;

    ckout_ratio #(
        .PRE_TOP (PRE_TOP),
        .PRE_W   (PRE_W),
        .FULL_W  (FULL_W),
        .HALF_W  (HALF_W)
    ) u_ratio (
        .pre_code  (cfg.pre_code),
        .fast_sel  (cfg.fast_sel),
        .post_exp  (cfg.post_exp),
        .half_m1   (half_m1),
        .unit_mode (unit_mode)
    );

    // Source select between the two strobe trains.
    assign src_stb = cfg.fast_sel ? fast_stb : slow_stb;

    // Half-period counter and output toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr || !cfg.en) begin
            cnt   <= '0;
            out_q <= 1'b0;
        end else if (unit_mode) begin
            cnt   <= '0;
            out_q <= src_stb;
        end else if (src_stb) begin
            if (cnt == half_m1) begin
                cnt   <= '0;
                out_q <= ~out_q;
            end else begin
                cnt   <= cnt + HALF_W'(1);
            end
        end
    end

    assign ck_out = out_q;

    assert_disabled_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> !out_q);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_stb && !cfg_wr && !unit_mode) |=> ($stable(out_q) && $stable(cnt)));

    assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_mode |-> (cnt <= half_m1));

    assert_unit_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_mode && $rose(out_q)) |-> $past(src_stb));

    assert_write_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!out_q && (cnt == '0)));

endmodule

// File: rtl/ckout_top.sv
// Module: ckout_top
// Register block plus NUM_CH identical divider channels sharing the two
// reference strobe trains.
// Assumes: both strobe trains and the register port are in the clk domain.
module ckout_top #(
    parameter int unsigned       NUM_CH    = 3,
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10,
    parameter int unsigned       PRE_TOP   = 122
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_stb,
    input  logic              fast_stb,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [NUM_CH-1:0] ck_out
);
    import ckout_pkg::*;

    logic [NUM_CH-1:0][CFG_W-1:0] cfg_q;
    logic [NUM_CH-1:0]            ch_wr;

    ckout_regs #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg_q (cfg_q),
        .ch_wr (ch_wr)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ckout_channel #(
            .PRE_TOP (PRE_TOP)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg      (ckout_cfg_t'(cfg_q[i])),
            .cfg_wr   (ch_wr[i]),
            .slow_stb (slow_stb),
            .fast_stb (fast_stb),
            .ck_out   (ck_out[i])
        );
    end

    assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wr));

endmodule

// File: tb/ckout_top_tb.sv
module ckout_top_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] BASE = 8'h10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_stb = 1'b0;
    logic       fast_stb = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] ck_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ckout_top u_dut (
        .clk(clk), .rst_n(rst_n), .slow_stb(slow_stb), .fast_stb(fast_stb),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ck_out(ck_out)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // One strobe on the chosen train; returns at the negedge after the sampling edge.
    task automatic pulse(bit fast);
        @(negedge clk);
        if (fast) fast_stb = 1'b1; else slow_stb = 1'b1;
        @(negedge clk);
        fast_stb = 1'b0; slow_stb = 1'b0;
    endtask

    task automatic pulses(bit fast, int n);
        for (int k = 0; k < n; k++) pulse(fast);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) rd_check("R1 reset", BASE + 8'(i), 8'h00);
        check("R1 reset outputs", ck_out, 0);
    endtask

    task automatic t_regs();
        wr(BASE, 8'hA5); wr(BASE + 1, 8'h3C); wr(BASE + 2, 8'hC2);
        rd_check("R1 ch0", BASE, 8'hA5);
        rd_check("R1 ch1", BASE + 1, 8'h3C);
        rd_check("R1 ch2", BASE + 2, 8'hC2);
        rd_check("R2 below", BASE - 1, 8'h00);
        rd_check("R2 above", BASE + 3, 8'h00);
        wr(BASE + 3, 8'hFF); wr(BASE - 1, 8'hFF);
        rd_check("R2 ch0 kept", BASE, 8'hA5);
        rd_check("R2 ch1 kept", BASE + 1, 8'h3C);
        rd_check("R2 ch2 kept", BASE + 2, 8'hC2);
        wr(BASE, 8'h00); wr(BASE + 1, 8'h00); wr(BASE + 2, 8'h00);
    endtask

    task automatic t_unit();
        wr(BASE, 8'h01);
        pulse(0);
        check("R9 high after strobe", ck_out[0], 1);
        @(negedge clk);
        check("R9 low one cycle later", ck_out[0], 0);
        pulse(1);
        check("R4 fast ignored on slow", ck_out[0], 0);
    endtask

    // Full period check: half = strobes per half period.
    task automatic t_period(string req, int ch, logic [7:0] cfg, bit fast, int half);
        wr(BASE + 8'(ch), cfg);
        if (half > 1) begin
            pulses(fast, half - 1);
            check({req, " before rise"}, ck_out[ch], 0);
        end
        pulses(!fast, 3);
        check("R4 other train ignored", ck_out[ch], 0);
        pulse(fast);
        check({req, " rise"}, ck_out[ch], 1);
        if (half > 1) begin
            pulses(fast, half - 1);
            check({req, " before fall"}, ck_out[ch], 1);
        end
        pulse(fast);
        check({req, " fall"}, ck_out[ch], 0);
    endtask

    task automatic t_disable();
        wr(BASE + 1, 8'h05);
        pulses(0, 2);
        check("R3 running", ck_out[1], 1);
        wr(BASE + 1, 8'h04);
        check("R3 forced low", ck_out[1], 0);
        pulses(0, 3);
        check("R3 stays low", ck_out[1], 0);
        wr(BASE + 1, 8'h05);
        pulse(0);
        check("R3 fresh period first", ck_out[1], 0);
        pulse(0);
        check("R3 fresh period rise", ck_out[1], 1);
    endtask

    task automatic t_rewrite();
        wr(BASE, 8'h07);
        pulses(0, 3);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = BASE; reg_wdata = 8'h07; slow_stb = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; slow_stb = 1'b0;
        check("R10 low after write", ck_out[0], 0);
        pulses(0, 3);
        check("R10 strobe at write not counted", ck_out[0], 0);
        pulse(0);
        check("R10 rise after restart", ck_out[0], 1);
    endtask

    task automatic t_indep();
        wr(BASE, 8'h03); wr(BASE + 1, 8'h05); wr(BASE + 2, 8'h00);
        pulse(0);
        check("R11 ch0 first", ck_out[0], 1);
        check("R11 ch1 first", ck_out[1], 0);
        wr(BASE + 2, 8'h01);
        pulse(0);
        check("R11 ch0 second", ck_out[0], 0);
        check("R11 ch1 second", ck_out[1], 1);
        check("R11 ch2 pulse", ck_out[2], 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_unit();
        t_period("R5 slow n=2", 1, 8'h05, 0, 2);
        t_period("R7 slow code ignored", 2, 8'hE3, 0, 1);
        t_period("R6 fast code7", 0, 8'hF1, 1, 61);
        t_period("R6 fast code3 n=2", 1, 8'h75, 1, 16);
        t_period("R5 fast n=7", 2, 8'h1F, 1, 64);
        t_period("R8 slow n=3", 0, 8'h07, 0, 4);
        t_disable();
        t_rewrite();
        t_indep();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule